// File: doc/BRIEF.md
# Four-Lane Seven-Slot Video Serializer

This block turns a 28-bit parallel pixel word into four serial data lanes and a forwarded clock lane. It runs entirely on a bit clock that is seven times the pixel rate. An internal slot counter divides the bit clock into pixel periods of seven slots. Once per period the block pulses a take strobe to the upstream logic, and it captures the word presented on that cycle. During the following period each lane sends seven bits of that word, chosen by a fixed scrambled permutation.

The forwarded clock lane repeats once per pixel period. It is high for the first four slots and low for the last three, so its rising edge marks slot 0 for the receiver. A single enable request, active high and asynchronous to the block, switches the output stage on and off. Dropping the request turns the outputs off within two bit clocks. Raising it starts a lock wait of a parameterised number of pixel periods, during which the outputs stay disabled. The output-enable pins model the high-impedance state of the line drivers.

Top module: `vid_ser7x4`

## Requirements
- R1: While the block is out of the off state, the slot counter steps 0,1,...,6,0 once per bit clock. The take strobe `wrd_take` is high exactly in the slot-6 cycle of every period, which makes it high once in every seven bit clocks.
- R2: The word presented on `pix_word` in a take cycle is sent during the next pixel period. Slot s (0..6) carries, on lanes 0,1,2,3: s0 = D1,D9,D20,D5; s1 = D0,D8,D19,D27; s2 = D7,D18,D26,D23; s3 = D6,D15,D25,D17; s4 = D4,D14,D24,D16; s5 = D3,D13,D22,D11; s6 = D2,D12,D21,D10. Lane n is bit n of `lane_o`.
- R3: Changes on `pix_word` outside take cycles have no effect on the lanes. The captured word stays constant for all seven slots.
- R4: While enabled, `fclk_o` reads 1,1,1,1,0,0,0 over slots 0..6, so its period is seven bit clocks and it rises at the start of slot 0.
- R5: After `en_req` falls, `dat_oe` and `fclk_oe` are low no later than the second rising bit-clock edge. Both enables always carry the same value.
- R6: After `en_req` rises, the enables become high at exactly the (SYNC_STAGES + 1 + 7*LOCK_PERIODS)-th rising edge, which is the 31st edge with the default parameters. If the request drops during the wait, the enables stay low.
- R7: While `dat_oe` is low, `lane_o` and `fclk_o` are 0. The slot counter rests at 0, so every enabled run begins with slot 0 and a rising forwarded clock.
- R8: While `rst_n` is low, the following are all 0: the enables, the lanes, the forwarded clock and the take strobe. This holds immediately, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven per pixel period |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Output enable request, asynchronous; low means shut down |
| pix_word | input | 28 | Parallel pixel word, sampled in take cycles |
| wrd_take | output | 1 | High in the cycle whose closing edge captures `pix_word` |
| lane_o | output | 4 | Serial data lanes, bit n = lane n |
| dat_oe | output | 1 | Data lane output enable |
| fclk_o | output | 1 | Forwarded clock lane |
| fclk_oe | output | 1 | Forwarded clock output enable |

## Verification
The hardest case to reach from the ports is a change of the input word in the middle of a period, while an earlier word is still being shifted out. Only that case tells a double-buffered capture apart from one that samples live input. The stimulus therefore loads a fresh random word on every bit clock, not just in take cycles. Each received period is rebuilt through the inverse permutation and compared against the word that was on the bus at the previous take. The bench also drops and raises the enable request at arbitrary slots, including partway through the lock wait. This exercises the restart at slot 0 and the exact lock-wait edge count.

// File: rtl/vidser_pkg.sv
package vidser_pkg;

  localparam int LANES    = 4;
  localparam int SLOTS    = 7;
  localparam int WORD_W   = LANES * SLOTS;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int CLK_HIGH = 4;

  // source bit for (slot, lane), index = slot*LANES + lane
  localparam int unsigned BIT_SRC [SLOTS*LANES] = '{
    1,  9, 20,  5,
    0,  8, 19, 27,
    7, 18, 26, 23,
    6, 15, 25, 17,
    4, 14, 24, 16,
    3, 13, 22, 11,
    2, 12, 21, 10
  };

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_LOCK = 2'd1,
    ST_RUN  = 2'd2
  } ser_st_e;

endpackage

// File: rtl/vs_en_sync.sv
module vs_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_nxt;
    end
  end

  assign dout = sh_q[STAGES-1];

  initial begin
    AST_SYNC_DEPTH: assert (STAGES >= 2); // R6
  end

endmodule

// File: rtl/vs_seq.sv
module vs_seq
  import vidser_pkg::*;
#(
  parameter int LOCK_PERIODS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_s,
  output logic [SLOT_W-1:0] slot_o,
  output logic              run_o,
  output logic              take_o
);

  localparam int LK_W = (LOCK_PERIODS > 1) ? $clog2(LOCK_PERIODS) : 1;
  localparam logic [LK_W-1:0]   LK_LAST   = LK_W'(LOCK_PERIODS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

  ser_st_e           st_q,   st_nxt;
  logic [SLOT_W-1:0] slot_q, slot_nxt;
  logic [LK_W-1:0]   lk_q,   lk_nxt;
  logic [SLOT_W-1:0] slot_inc;
  logic              wrap;

  always_comb begin
    wrap     = (slot_q == SLOT_LAST);
    slot_inc = wrap ? '0 : slot_q + 1'b1;
  end

  always_comb begin
    st_nxt   = st_q;
    slot_nxt = slot_q;
    lk_nxt   = lk_q;
    if (!en_s) begin
      st_nxt   = ST_OFF;
      slot_nxt = '0;
      lk_nxt   = '0;
    end else begin
      case (st_q)
        ST_OFF: begin
          st_nxt   = ST_LOCK;
          slot_nxt = '0;
          lk_nxt   = '0;
        end
        ST_LOCK: begin
          slot_nxt = slot_inc;
          if (wrap) begin
            if (lk_q == LK_LAST) begin
              st_nxt = ST_RUN;
              lk_nxt = '0;
            end else begin
              lk_nxt = lk_q + 1'b1;
            end
          end
        end
        ST_RUN: begin
          slot_nxt = slot_inc;
        end
        default: begin
          st_nxt   = ST_OFF;
          slot_nxt = '0;
          lk_nxt   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      slot_q <= '0;
      lk_q   <= '0;
    end else begin
      st_q   <= st_nxt;
      slot_q <= slot_nxt;
      lk_q   <= lk_nxt;
    end
  end

  assign slot_o = slot_q;
  assign run_o  = (st_q == ST_RUN);
  assign take_o = (st_q != ST_OFF) && wrap;

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= SLOT_LAST); // R1
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s && st_q != ST_OFF && !wrap) |=> (slot_q == $past(slot_q) + 1'b1)); // R1
  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s && st_q != ST_OFF && wrap) |=> (slot_q == '0)); // R1
  AST_OFF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF) |-> (slot_q == '0)); // R7
  AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> (slot_q == '0)); // R7
  AST_RUN_FROM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> ($past(st_q) == ST_LOCK && $past(lk_q) == LK_LAST)); // R6
  AST_LOCK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lk_q <= LK_LAST); // R6

endmodule

// File: rtl/vs_lanes.sv
module vs_lanes
  import vidser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              oe,
  input  logic [SLOT_W-1:0] slot,
  input  logic [WORD_W-1:0] word_i,
  output logic [LANES-1:0]  lanes_o
);

  logic [WORD_W-1:0] cap_q, cap_nxt;

  always_comb begin
    cap_nxt = take ? word_i : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else begin
      cap_q <= cap_nxt;
    end
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic bit_sel;
    always_comb begin
      bit_sel = 1'b0;
      for (int s = 0; s < SLOTS; s++) begin
        if (slot == SLOT_W'(s)) begin
          bit_sel = cap_q[BIT_SRC[s*LANES + ln]];
        end
      end
    end
    assign lanes_o[ln] = oe & bit_sel;
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cap_q)); // R3
  AST_LANES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (lanes_o == '0)); // R7

endmodule

// File: rtl/vs_fclk.sv
module vs_fclk
  import vidser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oe,
  input  logic [SLOT_W-1:0] slot,
  output logic              fclk_o
);

  assign fclk_o = oe && (slot < SLOT_W'(CLK_HIGH));

  AST_FCLK_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fclk_o) |-> (slot == '0)); // R4
  AST_FCLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !fclk_o); // R7

endmodule

// File: rtl/vid_ser7x4.sv
module vid_ser7x4
  import vidser_pkg::*;
#(
  parameter int LOCK_PERIODS = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req,
  input  logic [WORD_W-1:0] pix_word,
  output logic              wrd_take,
  output logic [LANES-1:0]  lane_o,
  output logic              dat_oe,
  output logic              fclk_o,
  output logic              fclk_oe
);

  logic              en_s;
  logic              run;
  logic [SLOT_W-1:0] slot;
  logic              oe;

  vs_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (en_req),
    .dout  (en_s)
  );

  vs_seq #(.LOCK_PERIODS(LOCK_PERIODS)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_s   (en_s),
    .slot_o (slot),
    .run_o  (run),
    .take_o (wrd_take)
  );

  // the synchronized request gates the enables directly so shutdown
  // does not wait for the state register
  assign oe = run & en_s;

  vs_lanes u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (wrd_take),
    .oe      (oe),
    .slot    (slot),
    .word_i  (pix_word),
    .lanes_o (lane_o)
  );

  vs_fclk u_fclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .oe     (oe),
    .slot   (slot),
    .fclk_o (fclk_o)
  );

  assign dat_oe  = oe;
  assign fclk_oe = oe;

  AST_SHDN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |-> (!dat_oe && !fclk_oe)); // R5
  AST_TAKE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_oe && wrd_take) |=> !wrd_take); // R1

endmodule

// File: tb/sim_vid_ser7x4.sv
`timescale 1ns/1ps
module sim_vid_ser7x4;

  localparam int LOCKP = 4;
  localparam int SYNC  = 2;
  localparam int ON_EDGE = SYNC + 1 + 7*LOCKP;

  localparam int unsigned TB_MAP [28] = '{
    1,  9, 20,  5,
    0,  8, 19, 27,
    7, 18, 26, 23,
    6, 15, 25, 17,
    4, 14, 24, 16,
    3, 13, 22, 11,
    2, 12, 21, 10
  };

  logic        clk;
  logic        rst_n;
  logic        en_req;
  logic [27:0] pix_word;
  logic        wrd_take;
  logic [3:0]  lane_o;
  logic        dat_oe;
  logic        fclk_o;
  logic        fclk_oe;

  int n_chk;
  int n_bad;
  int mode;      // 0 random per cycle, 1 constant hold
  logic [27:0] hold_w;
  bit mon_on;

  vid_ser7x4 #(.LOCK_PERIODS(LOCKP), .SYNC_STAGES(SYNC)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_req   (en_req),
    .pix_word (pix_word),
    .wrd_take (wrd_take),
    .lane_o   (lane_o),
    .dat_oe   (dat_oe),
    .fclk_o   (fclk_o),
    .fclk_oe  (fclk_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  // word driver: new value shortly after each rising edge
  always @(posedge clk) begin
    #1;
    if (mode == 0) pix_word <= 28'($urandom);
    else           pix_word <= hold_w;
  end

  // receiver model
  int          bs;
  logic        pf;
  logic [27:0] last_tk, exp_w, got_w;
  logic [6:0]  pat;

  always @(negedge clk) begin
    if (mon_on) begin
      chk(fclk_oe == dat_oe, "R5", {31'd0, fclk_oe}, {31'd0, dat_oe});
      if (!dat_oe) begin
        chk(lane_o == 4'd0 && fclk_o == 1'b0, "R7", {27'd0, fclk_o, lane_o}, 32'd0);
        bs = -1;
      end else begin
        if (fclk_o && !pf) begin
          bs = 0; exp_w = last_tk; got_w = '0; pat = '0;
        end else if (bs >= 0) begin
          bs++;
        end
        if (bs > 6) begin
          chk(1'b0, "R4", 32'(bs), 32'd0);
          bs = -1;
        end else if (bs >= 0) begin
          for (int l = 0; l < 4; l++) got_w[TB_MAP[bs*4 + l]] = lane_o[l];
          pat[6-bs] = fclk_o;
          chk(wrd_take == (bs == 6), "R1", {31'd0, wrd_take}, {31'd0, bs == 6});
          if (bs == 6) begin
            chk(got_w == exp_w, "R2 R3", {4'd0, got_w}, {4'd0, exp_w});
            chk(pat == 7'b1111000, "R4", {25'd0, pat}, 32'h78);
          end
        end
      end
      if (wrd_take) last_tk = pix_word;
      pf = fclk_o & dat_oe;
    end
  end

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  // raise the request just after an edge and check the enable edge count
  task automatic enable_and_check();
    @(posedge clk); #1 en_req = 1'b1;
    edges(ON_EDGE - 1);
    @(negedge clk);
    chk(dat_oe == 1'b0, "R6", {31'd0, dat_oe}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk(dat_oe == 1'b1, "R6", {31'd0, dat_oe}, 32'd1);
    chk(fclk_o == 1'b1, "R7", {31'd0, fclk_o}, 32'd1);
  endtask

  task automatic shutdown_and_check();
    @(posedge clk); #1 en_req = 1'b0;
    edges(2);
    @(negedge clk);
    chk(dat_oe == 1'b0 && fclk_oe == 1'b0, "R5", {30'd0, dat_oe, fclk_oe}, 32'd0);
    chk(lane_o == 4'd0 && fclk_o == 1'b0, "R7", {27'd0, fclk_o, lane_o}, 32'd0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; mode = 0; hold_w = '0; mon_on = 1'b0;
    bs = -1; pf = 1'b0; last_tk = '0; exp_w = '0; got_w = '0; pat = '0;
    void'($urandom(32'd1357));
    rst_n = 1'b0; en_req = 1'b0; pix_word = '0;
    #1;
    chk(dat_oe == 0 && fclk_oe == 0 && lane_o == 0 && fclk_o == 0 && wrd_take == 0,
        "R8", {27'd0, dat_oe, fclk_oe, fclk_o, wrd_take, 1'b0}, 32'd0);
    edges(4);
    @(negedge clk);
    chk(dat_oe == 0 && wrd_take == 0, "R8", {30'd0, dat_oe, wrd_take}, 32'd0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // random words changing every bit clock
    enable_and_check();
    edges(400);

    // directed constant patterns
    mode = 1;
    hold_w = 28'h0000000; edges(21);
    hold_w = 28'hFFFFFFF; edges(21);
    hold_w = 28'h5555555; edges(21);
    hold_w = 28'hAAAAAAA; edges(21);
    for (int k = 0; k < 28; k += 3) begin
      hold_w = 28'(1) << k; edges(14);
    end
    mode = 0;

    // shutdown at assorted slots, then restart
    for (int r = 0; r < 5; r++) begin
      edges(3 + r);
      shutdown_and_check();
      edges(5);
      enable_and_check();
      edges(70);
    end

    // request dropped during the lock wait
    @(posedge clk); #1 en_req = 1'b1;
    edges(12);
    #1 en_req = 1'b0;
    edges(ON_EDGE + 4);
    @(negedge clk);
    chk(dat_oe == 1'b0, "R6", {31'd0, dat_oe}, 32'd0);
    enable_and_check();
    edges(200);

    // asynchronous reset in the middle of a run
    @(posedge clk); #2 rst_n = 1'b0;
    #1;
    chk(dat_oe == 0 && fclk_o == 0 && lane_o == 0 && wrd_take == 0,
        "R8", {27'd0, dat_oe, fclk_o, lane_o[0], wrd_take, 1'b0}, 32'd0);
    en_req = 1'b0;
    edges(3);
    @(negedge clk); rst_n = 1'b1;
    enable_and_check();
    edges(100);

    finish_run();
  end

  initial begin
    edges(150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    finish_run();
  end

endmodule